// File: doc/BRIEF.md
# Reset Type Controller

This block sorts incoming reset conditions by kind and drives five separate active-low reset outputs. The outputs go to test and emulation logic, the CPU emulator, the DSP emulator, the main chip logic and the DSP local domain. It looks at two pins and two requests. The first pin is an active-low external reset. The second is an active-low test reset. The requests are a watchdog timeout pulse and an emulator reset request.

Driving both pins low at once is a cold reset. It resets every domain, including test and emulation logic. Driving only the external pin low, with the test reset pin high, is a warm reset. A warm reset leaves the test logic and the CPU emulator running, but resets the DSP emulator and the rest of the chip. A watchdog timeout or an emulator request starts a maximum reset, which has the same effect as a warm reset.

All four inputs pass through two-flop synchronizers before they are used. A cold reset also asserts its outputs asynchronously, and every output is released on a clock edge. Each output stays asserted for a set number of cycles after its cause ends. The cold-only outputs and the system-wide outputs each have their own hold count. A two-bit code keeps the kind of the most recent reset.

Top module: `reset_type_ctrl`

## Requirements
- R1: When `ext_rst_n` and `test_rst_n` are both low, all five reset outputs go low at once, without waiting for a clock edge.
- R2: `test_logic_rst_n` and `cpu_emu_rst_n` are driven low only by a cold reset. Warm reset, watchdog and emulator requests leave them high.
- R3: When `ext_rst_n` is low and `test_rst_n` is high, `chip_rst_n`, `dsp_emu_rst_n` and `dsp_local_rst_n` go low.
- R4: A pulse on `wdog_pulse`, or on `emu_rst_req`, drives the same three outputs low as a warm reset does.
- R5: `last_cause` encodes 2'b00 for a cold reset, 2'b01 for warm, 2'b10 for watchdog and 2'b11 for emulator. When several causes are active in the same cycle, the priority is cold, then warm, then watchdog, then emulator.
- R6: A watchdog or emulator pulse that is high for L rising edges holds the three system outputs low for exactly L+SYS_HOLD cycles. After a cold reset ends, the cold-only outputs rise on the (COLD_HOLD+3)th rising edge after the pins are released, and the system outputs rise on the (SYS_HOLD+3)th.
- R7: `last_cause` keeps its value while no cause is active. Toggling `test_rst_n` while `ext_rst_n` is high changes neither the outputs nor `last_cause`.
- R8: A cold reset sets `last_cause` to 2'b00, whatever cause was recorded before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| test_rst_n | input | 1 | Test reset pin, active low, asynchronous |
| wdog_pulse | input | 1 | Watchdog timeout request, active high |
| emu_rst_req | input | 1 | Emulator reset request, active high |
| test_logic_rst_n | output | 1 | Reset for test and emulation logic, active low |
| cpu_emu_rst_n | output | 1 | Reset for the CPU emulator, active low |
| dsp_emu_rst_n | output | 1 | Reset for the DSP emulator, active low |
| chip_rst_n | output | 1 | Reset for the main chip logic, active low |
| dsp_local_rst_n | output | 1 | Reset for the DSP local domain, active low |
| last_cause | output | 2 | Code of the most recent reset kind |

## Verification
The bound assertions check on every cycle:
- that each synchronized cause asserts the right group of outputs on the next edge;
- that the cold-only outputs fall only after a cold condition, and that the system outputs rise only when no cause is active;
- that the recorded cause follows the priority order and holds when no cause is active.

Some behaviour only the bench scenarios can show:
- the exact length of each stretched reset, counted in cycles;
- the asynchronous assertion before any clock edge;
- the priority outcome when two requests arrive together;
- that a lone toggle of the test reset pin has no effect.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef enum logic [1:0] {
    CAUSE_COLD = 2'b00,
    CAUSE_WARM = 2'b01,
    CAUSE_WDOG = 2'b10,
    CAUSE_EMU  = 2'b11
  } rst_cause_e;

  // synchronized input lanes
  localparam int unsigned LANE_EXT  = 0;
  localparam int unsigned LANE_TRST = 1;
  localparam int unsigned LANE_WDOG = 2;
  localparam int unsigned LANE_EMU  = 3;
  localparam int unsigned NUM_LANES = 4;

  // stretch domains
  localparam int unsigned DOM_COLD = 0;
  localparam int unsigned DOM_SYS  = 1;
  localparam int unsigned NUM_DOMS = 2;

endpackage

// File: rtl/rtc_sync.sv
module rtc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/rtc_classify.sv
module rtc_classify
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       arst_n,
  input  logic       ext_s,
  input  logic       trst_s,
  input  logic       wdog_s,
  input  logic       emu_s,
  output logic       cold_req,
  output logic       sys_req,
  output logic [1:0] cause
);

  logic       cold_c;
  logic       warm_c;
  logic       any_c;
  rst_cause_e cause_d;
  rst_cause_e cause_q;
  logic       cause_en;

  always_comb begin
    cold_c   = !ext_s && !trst_s;
    warm_c   = !ext_s &&  trst_s;
    any_c    = !ext_s || wdog_s || emu_s;
    cause_en = any_c;
    if (cold_c) begin
      cause_d = CAUSE_COLD;
    end else if (warm_c) begin
      cause_d = CAUSE_WARM;
    end else if (wdog_s) begin
      cause_d = CAUSE_WDOG;
    end else begin
      cause_d = CAUSE_EMU;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cause_q <= CAUSE_COLD;
    end else if (cause_en) begin
      cause_q <= cause_d;
    end
  end

  assign cold_req = cold_c;
  assign sys_req  = any_c;
  assign cause    = cause_q;

endmodule

// File: rtl/rtc_stretch.sv
module rtc_stretch #(
  parameter int unsigned HOLD = 8
) (
  input  logic clk,
  input  logic arst_n,
  input  logic req,
  output logic rst_n_o
);

  localparam int unsigned CW = (HOLD < 1) ? 1 : $clog2(HOLD + 1);
  localparam logic [CW-1:0] HOLD_V = CW'(HOLD);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          out_q;
  logic          out_d;
  logic          busy;

  always_comb begin
    busy = (cnt_q != '0);
    if (req) begin
      cnt_d = HOLD_V;
    end else if (busy) begin
      cnt_d = cnt_q - 1'b1;
    end else begin
      cnt_d = cnt_q;
    end
    out_d = !(req || busy);
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cnt_q <= HOLD_V;
      out_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      out_q <= out_d;
    end
  end

  assign rst_n_o = out_q;

endmodule

// File: rtl/reset_type_ctrl.sv
module reset_type_ctrl
  import rtc_pkg::*;
#(
  parameter int unsigned COLD_HOLD   = 16,
  parameter int unsigned SYS_HOLD    = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       ext_rst_n,
  input  logic       test_rst_n,
  input  logic       wdog_pulse,
  input  logic       emu_rst_req,
  output logic       test_logic_rst_n,
  output logic       cpu_emu_rst_n,
  output logic       dsp_emu_rst_n,
  output logic       chip_rst_n,
  output logic       dsp_local_rst_n,
  output logic [1:0] last_cause
);

  logic                 cold_async_n;
  logic [NUM_LANES-1:0] raw_in;
  logic [NUM_LANES-1:0] sync_in;
  logic                 ext_s;
  logic                 trst_s;
  logic                 wdog_s;
  logic                 emu_s;
  logic                 cold_req;
  logic                 sys_req;
  logic [NUM_DOMS-1:0]  dom_req;
  logic [NUM_DOMS-1:0]  dom_rst_n;

  // cold condition: both pins low, applied asynchronously
  assign cold_async_n = ext_rst_n | test_rst_n;

  always_comb begin
    raw_in            = '0;
    raw_in[LANE_EXT]  = ext_rst_n;
    raw_in[LANE_TRST] = test_rst_n;
    raw_in[LANE_WDOG] = wdog_pulse;
    raw_in[LANE_EMU]  = emu_rst_req;
  end

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_sync
    rtc_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .arst_n (cold_async_n),
      .d      (raw_in[g]),
      .q      (sync_in[g])
    );
  end

  assign ext_s  = sync_in[LANE_EXT];
  assign trst_s = sync_in[LANE_TRST];
  assign wdog_s = sync_in[LANE_WDOG];
  assign emu_s  = sync_in[LANE_EMU];

  rtc_classify u_classify (
    .clk      (clk),
    .arst_n   (cold_async_n),
    .ext_s    (ext_s),
    .trst_s   (trst_s),
    .wdog_s   (wdog_s),
    .emu_s    (emu_s),
    .cold_req (cold_req),
    .sys_req  (sys_req),
    .cause    (last_cause)
  );

  always_comb begin
    dom_req           = '0;
    dom_req[DOM_COLD] = cold_req;
    dom_req[DOM_SYS]  = sys_req;
  end

  for (genvar d = 0; d < NUM_DOMS; d++) begin : g_dom
    localparam int unsigned DOM_HOLD = (d == DOM_COLD) ? COLD_HOLD : SYS_HOLD;
    rtc_stretch #(.HOLD(DOM_HOLD)) u_stretch (
      .clk     (clk),
      .arst_n  (cold_async_n),
      .req     (dom_req[d]),
      .rst_n_o (dom_rst_n[d])
    );
  end

  assign test_logic_rst_n = dom_rst_n[DOM_COLD];
  assign cpu_emu_rst_n    = dom_rst_n[DOM_COLD];
  assign dsp_emu_rst_n    = dom_rst_n[DOM_SYS];
  assign chip_rst_n       = dom_rst_n[DOM_SYS];
  assign dsp_local_rst_n  = dom_rst_n[DOM_SYS];

endmodule

// File: rtl/reset_type_ctrl_chk.sv
module reset_type_ctrl_chk (
  input logic       clk,
  input logic       arst_n,
  input logic       ext_s,
  input logic       trst_s,
  input logic       wdog_s,
  input logic       emu_s,
  input logic       test_logic_rst_n,
  input logic       cpu_emu_rst_n,
  input logic       dsp_emu_rst_n,
  input logic       chip_rst_n,
  input logic       dsp_local_rst_n,
  input logic [1:0] last_cause
);

  AST_COLD_HITS_ALL: assert property (@(posedge clk) disable iff (!arst_n)
    (!ext_s && !trst_s) |=> (!test_logic_rst_n && !cpu_emu_rst_n && !dsp_emu_rst_n
                             && !chip_rst_n && !dsp_local_rst_n)); // R1

  AST_CPU_EMU_COLD_ONLY: assert property (@(posedge clk) disable iff (!arst_n)
    $fell(cpu_emu_rst_n) |-> $past(!ext_s && !trst_s)); // R2

  AST_TEST_LOGIC_COLD_ONLY: assert property (@(posedge clk) disable iff (!arst_n)
    $fell(test_logic_rst_n) |-> $past(!ext_s && !trst_s)); // R2

  AST_WARM_HITS_SYS: assert property (@(posedge clk) disable iff (!arst_n)
    (!ext_s && trst_s) |=> (!chip_rst_n && !dsp_emu_rst_n && !dsp_local_rst_n)); // R3

  AST_MAX_HITS_SYS: assert property (@(posedge clk) disable iff (!arst_n)
    (wdog_s || emu_s) |=> (!chip_rst_n && !dsp_emu_rst_n && !dsp_local_rst_n)); // R4

  AST_WARM_OVER_MAX: assert property (@(posedge clk) disable iff (!arst_n)
    (!ext_s && trst_s) |=> (last_cause == 2'b01)); // R5

  AST_WDOG_OVER_EMU: assert property (@(posedge clk) disable iff (!arst_n)
    (ext_s && wdog_s) |=> (last_cause == 2'b10)); // R5

  AST_SYS_RELEASE_IDLE: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(chip_rst_n) |-> $past(ext_s && !wdog_s && !emu_s)); // R6

  AST_CAUSE_HOLDS: assert property (@(posedge clk) disable iff (!arst_n)
    (ext_s && !wdog_s && !emu_s) |=> $stable(last_cause)); // R7

  AST_COLD_CLEARS_CAUSE: assert property (@(posedge clk) disable iff (!arst_n)
    (!ext_s && !trst_s) |=> (last_cause == 2'b00)); // R8

endmodule

bind reset_type_ctrl reset_type_ctrl_chk u_chk (
  .clk              (clk),
  .arst_n           (cold_async_n),
  .ext_s            (ext_s),
  .trst_s           (trst_s),
  .wdog_s           (wdog_s),
  .emu_s            (emu_s),
  .test_logic_rst_n (test_logic_rst_n),
  .cpu_emu_rst_n    (cpu_emu_rst_n),
  .dsp_emu_rst_n    (dsp_emu_rst_n),
  .chip_rst_n       (chip_rst_n),
  .dsp_local_rst_n  (dsp_local_rst_n),
  .last_cause       (last_cause)
);

// File: tb/reset_type_ctrl_bench.sv
`timescale 1ns/1ps
module reset_type_ctrl_bench;

  localparam int unsigned COLD_HOLD = 10;
  localparam int unsigned SYS_HOLD  = 4;

  logic       clk;
  logic       ext_rst_n;
  logic       test_rst_n;
  logic       wdog_pulse;
  logic       emu_rst_req;
  logic       test_logic_rst_n;
  logic       cpu_emu_rst_n;
  logic       dsp_emu_rst_n;
  logic       chip_rst_n;
  logic       dsp_local_rst_n;
  logic [1:0] last_cause;

  int checks;
  int failures;
  bit done;

  reset_type_ctrl #(.COLD_HOLD(COLD_HOLD), .SYS_HOLD(SYS_HOLD)) u_reset_type_ctrl (
    .clk              (clk),
    .ext_rst_n        (ext_rst_n),
    .test_rst_n       (test_rst_n),
    .wdog_pulse       (wdog_pulse),
    .emu_rst_req      (emu_rst_req),
    .test_logic_rst_n (test_logic_rst_n),
    .cpu_emu_rst_n    (cpu_emu_rst_n),
    .dsp_emu_rst_n    (dsp_emu_rst_n),
    .chip_rst_n       (chip_rst_n),
    .dsp_local_rst_n  (dsp_local_rst_n),
    .last_cause       (last_cause)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int outs();
    return {27'd0, test_logic_rst_n, cpu_emu_rst_n, dsp_emu_rst_n, chip_rst_n, dsp_local_rst_n};
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // cold reset, then release and measure both release edges
  task automatic t_cold(input string tag);
    int first_cold;
    int first_sys;
    @(negedge clk);
    test_rst_n = 1'b0;
    ext_rst_n  = 1'b0;
    #1;
    chk({tag, " R1 async all low"}, outs(), 0);
    idle(3);
    chk({tag, " R8 cause cold"}, last_cause, 0);
    @(negedge clk);
    ext_rst_n = 1'b1;
    first_cold = 0;
    first_sys  = 0;
    for (int e = 1; e <= 40; e++) begin
      @(posedge clk);
      #1;
      if (first_cold == 0 && test_logic_rst_n) first_cold = e;
      if (first_sys == 0 && chip_rst_n) first_sys = e;
    end
    chk({tag, " R6 cold release edge"}, first_cold, COLD_HOLD + 3);
    chk({tag, " R6 sys release edge"}, first_sys, SYS_HOLD + 3);
    chk({tag, " R2 cpu emu released"}, cpu_emu_rst_n, 1);
    @(negedge clk);
    test_rst_n = 1'b1;
    idle(4);
  endtask

  task automatic t_warm();
    int cpu_low;
    int tst_low;
    cpu_low = 0;
    tst_low = 0;
    @(negedge clk);
    ext_rst_n = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (!cpu_emu_rst_n) cpu_low++;
      if (!test_logic_rst_n) tst_low++;
    end
    chk("R3 warm chip/dspemu/dsplocal low", {chip_rst_n, dsp_emu_rst_n, dsp_local_rst_n}, 0);
    chk("R5 warm cause", last_cause, 1);
    ext_rst_n = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!cpu_emu_rst_n) cpu_low++;
      if (!test_logic_rst_n) tst_low++;
    end
    chk("R2 warm spares cpu emu", cpu_low, 0);
    chk("R2 warm spares test logic", tst_low, 0);
    chk("R3 warm released", chip_rst_n, 1);
  endtask

  // pulse on watchdog (which=0) or emulator (which=1) for len edges
  task automatic t_max(input int which, input int len);
    int sys_low;
    int dsp_low;
    int cold_low;
    sys_low  = 0;
    dsp_low  = 0;
    cold_low = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (!chip_rst_n) sys_low++;
      if (!dsp_emu_rst_n && !dsp_local_rst_n) dsp_low++;
      if (!cpu_emu_rst_n || !test_logic_rst_n) cold_low++;
      if (which == 0) wdog_pulse = (i < len);
      else emu_rst_req = (i < len);
    end
    chk(which == 0 ? "R6 wdog stretch length" : "R6 emu stretch length", sys_low, len + SYS_HOLD);
    chk("R4 dsp outputs follow max reset", dsp_low, len + SYS_HOLD);
    chk("R2 max reset spares cold outputs", cold_low, 0);
    chk("R5 max cause code", last_cause, which == 0 ? 2 : 3);
  endtask

  task automatic t_priority();
    @(negedge clk);
    wdog_pulse  = 1'b1;
    emu_rst_req = 1'b1;
    @(negedge clk);
    wdog_pulse  = 1'b0;
    emu_rst_req = 1'b0;
    idle(20);
    chk("R5 wdog beats emu", last_cause, 2);
    @(negedge clk);
    ext_rst_n   = 1'b0;
    emu_rst_req = 1'b1;
    idle(3);
    ext_rst_n   = 1'b1;
    emu_rst_req = 1'b0;
    idle(20);
    chk("R5 warm beats emu", last_cause, 1);
  endtask

  task automatic t_trst_toggle();
    int changes;
    int base;
    changes = 0;
    base = outs();
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      test_rst_n = (i % 6) < 3;
      if (outs() != base) changes++;
    end
    test_rst_n = 1'b1;
    idle(4);
    chk("R7 test pin alone no output change", changes, 0);
    chk("R7 cause held", last_cause, 1);
  endtask

  initial begin
    checks = 0;
    failures = 0;
    done = 1'b0;
    ext_rst_n   = 1'b0;
    test_rst_n  = 1'b0;
    wdog_pulse  = 1'b0;
    emu_rst_req = 1'b0;
    #1;
    chk("R1 reset state outputs", outs(), 0);
    chk("R8 reset state cause", last_cause, 0);
    idle(3);
    ext_rst_n  = 1'b1;
    test_rst_n = 1'b1;
    idle(COLD_HOLD + 8);
    chk("R1 outputs released after power-up", outs(), 31);
    t_warm();
    t_max(0, 1);
    t_max(1, 3);
    t_max(0, 5);
    t_priority();
    t_trst_toggle();
    t_max(0, 2);
    t_cold("after wdog");
    t_max(1, 1);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule